// File: doc/BRIEF.md
# ADC Power-Down Sequencer

This block sits on the host side of a parallel-output sampling converter. It owns two pins of that converter: an active-low power-down line and an active-low select line. It moves the converter between full operation and two low-power states. In the light state the select line is held low during power-down, and the converter keeps its digital logic, its reference and its last result alive. In the deep state the select line is held high during power-down, and almost everything is switched off.

The host raises single-cycle requests for nap, sleep or wake. On a wake, the block drives the converter pins back to operating levels. It then holds its ready flag low for a recovery window counted in system clock cycles. The window is short after the light state and long after the deep state, because the reference must settle again. Conversion requests from the host are passed through only while the block reports ready.

A move from the light state to the deep state is done by raising the select line while the power-down line stays low. Both recovery windows are parameters. Their defaults assume a 125 MHz clock: 50 cycles and 20,000,000 cycles.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset the block is operating: `pwr_state` is 0, `adc_shdn_n` is 1, `adc_cs_n` is 0 and `ready` is 1.
- R2: A nap request while operating moves the block, from the next cycle, to state 1. In state 1, `adc_shdn_n` is 0, `adc_cs_n` is 0 and `ready` is 0.
- R3: A sleep request while operating moves the block, from the next cycle, to state 2. In state 2, `adc_shdn_n` is 0, `adc_cs_n` is 1 and `ready` is 0.
- R4: A sleep request in state 1 moves the block to state 2. `adc_cs_n` rises while `adc_shdn_n` stays low throughout.
- R5: A wake request in state 1 moves the block to state 3 for exactly NAP_WAKE_CYC cycles, then to state 0. In state 3, `adc_shdn_n` is 1, `adc_cs_n` is 0 and `ready` is 0.
- R6: A wake request in state 2 moves the block to state 3 for exactly SLEEP_WAKE_CYC cycles, then to state 0, with the same pin levels as in R5.
- R7: Some requests have no effect: a wake while in state 0, a nap while in state 1 or state 2, and any request while in state 3. The state and pins stay as they were.
- R8: `conv_grant` equals `conv_req` while `ready` is 1, and is 0 otherwise.
- R9: When requests coincide, sleep beats nap and nap beats wake. In state 1, sleep beats wake.
- R10: The `pwr_state` encoding is 0 operating, 1 nap, 2 sleep, 3 waking. `ready` is 1 exactly in state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_nap | input | 1 | Request the light power-down state |
| req_sleep | input | 1 | Request the deep power-down state |
| req_wake | input | 1 | Request return to operation |
| conv_req | input | 1 | Host wants to start a conversion |
| conv_grant | output | 1 | Conversion start passed to the converter |
| adc_shdn_n | output | 1 | Converter power-down line, low = powered down |
| adc_cs_n | output | 1 | Converter select line, low = selected |
| ready | output | 1 | Converter usable; recovery window complete |
| pwr_state | output | 2 | Current power state (encoding in R10) |

## Verification
Both pins are decoded from the state register, so a wrong state shows on `adc_shdn_n`, `adc_cs_n`, `ready` and `pwr_state` in the same cycle it is entered. A wrong recovery count appears only when the waking window closes. It shows up as `ready` rising one or more cycles early or late. A wrong choice of which delay to load shows up as the nap-length window being used after sleep, or the sleep-length window after nap. The reference model therefore checks every cycle, across both wake paths and across coinciding requests.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

   typedef enum logic [1:0] {
      PS_ACTIVE = 2'd0,
      PS_NAP    = 2'd1,
      PS_SLEEP  = 2'd2,
      PS_WAKING = 2'd3
   } pwr_state_e;

   // Power-down line: low only in the two low-power states.
   function automatic logic pin_shdn_n(input pwr_state_e st);
      return !((st == PS_NAP) || (st == PS_SLEEP));
   endfunction

   // Select line: high only in deep power-down (selects sleep over nap).
   function automatic logic pin_cs_n(input pwr_state_e st);
      return (st == PS_SLEEP);
   endfunction

endpackage

// File: rtl/adc_pwr_wake_timer.sv
module adc_pwr_wake_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          done
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (run && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
   import adc_pwr_pkg::*;
#(
   parameter int NAP_WAKE_CYC   = 50,
   parameter int SLEEP_WAKE_CYC = 20_000_000,
   parameter int CW             = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_nap,
   input  logic          req_sleep,
   input  logic          req_wake,
   input  logic          tmr_done,
   output pwr_state_e    state_q,
   output pwr_state_e    state_nxt,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val
);
   localparam logic [CW-1:0] NAP_LOAD   = CW'(NAP_WAKE_CYC - 1);
   localparam logic [CW-1:0] SLEEP_LOAD = CW'(SLEEP_WAKE_CYC - 1);

   always_comb begin
      state_nxt = state_q;
      tmr_load  = 1'b0;
      tmr_val   = NAP_LOAD;
      unique case (state_q)
         PS_ACTIVE: begin
            if (req_sleep)    state_nxt = PS_SLEEP;
            else if (req_nap) state_nxt = PS_NAP;
         end
         PS_NAP: begin
            if (req_sleep) state_nxt = PS_SLEEP;
            else if (req_wake) begin
               state_nxt = PS_WAKING;
               tmr_load  = 1'b1;
               tmr_val   = NAP_LOAD;
            end
         end
         PS_SLEEP: begin
            if (req_wake) begin
               state_nxt = PS_WAKING;
               tmr_load  = 1'b1;
               tmr_val   = SLEEP_LOAD;
            end
         end
         PS_WAKING: begin
            if (tmr_done) state_nxt = PS_ACTIVE;
         end
         default: state_nxt = PS_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_ACTIVE;
      else        state_q <= state_nxt;
   end
endmodule

// File: rtl/adc_pwr_pin_drive.sv
module adc_pwr_pin_drive
   import adc_pwr_pkg::*;
#(
   parameter bit REG_PINS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pwr_state_e state_q,
   input  pwr_state_e state_nxt,
   output logic       shdn_n,
   output logic       cs_n
);
   generate
      if (REG_PINS) begin : g_reg
         // Registered from next state: pins move on the same edge as the state.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shdn_n <= 1'b1;
               cs_n   <= 1'b0;
            end else begin
               shdn_n <= pin_shdn_n(state_nxt);
               cs_n   <= pin_cs_n(state_nxt);
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n ^ (state_nxt == PS_ACTIVE);
         assign shdn_n = pin_shdn_n(state_q);
         assign cs_n   = pin_cs_n(state_q);
      end
   endgenerate
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
   import adc_pwr_pkg::*;
#(
   parameter int NAP_WAKE_CYC   = 50,
   parameter int SLEEP_WAKE_CYC = 20_000_000,
   parameter bit REG_PINS       = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_nap,
   input  logic       req_sleep,
   input  logic       req_wake,
   input  logic       conv_req,
   output logic       conv_grant,
   output logic       adc_shdn_n,
   output logic       adc_cs_n,
   output logic       ready,
   output logic [1:0] pwr_state
);
   localparam int MAX_WAKE = (NAP_WAKE_CYC > SLEEP_WAKE_CYC) ? NAP_WAKE_CYC : SLEEP_WAKE_CYC;
   localparam int CW       = (MAX_WAKE < 2) ? 1 : $clog2(MAX_WAKE);

   generate
      if (NAP_WAKE_CYC < 1) begin : g_bad_nap
         $error("NAP_WAKE_CYC must be at least 1");
      end
      if (SLEEP_WAKE_CYC < 1) begin : g_bad_sleep
         $error("SLEEP_WAKE_CYC must be at least 1");
      end
   endgenerate

   pwr_state_e    st_q, st_nxt;
   logic          tmr_load, tmr_done;
   logic [CW-1:0] tmr_val;

   adc_pwr_fsm #(
      .NAP_WAKE_CYC  (NAP_WAKE_CYC),
      .SLEEP_WAKE_CYC(SLEEP_WAKE_CYC),
      .CW            (CW)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_nap  (req_nap),
      .req_sleep(req_sleep),
      .req_wake (req_wake),
      .tmr_done (tmr_done),
      .state_q  (st_q),
      .state_nxt(st_nxt),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val)
   );

   adc_pwr_wake_timer #(.CW(CW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .run     (st_q == PS_WAKING),
      .done    (tmr_done)
   );

   adc_pwr_pin_drive #(.REG_PINS(REG_PINS)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_q  (st_q),
      .state_nxt(st_nxt),
      .shdn_n   (adc_shdn_n),
      .cs_n     (adc_cs_n)
   );

   assign ready      = (st_q == PS_ACTIVE);
   assign conv_grant = conv_req && ready;
   assign pwr_state  = st_q;
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
   parameter int NAP_WAKE_CYC   = 50,
   parameter int SLEEP_WAKE_CYC = 20_000_000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_nap,
   input logic       req_sleep,
   input logic       req_wake,
   input logic       conv_req,
   input logic       conv_grant,
   input logic       adc_shdn_n,
   input logic       adc_cs_n,
   input logic       ready,
   input logic [1:0] pwr_state
);
   int   wcnt;
   logic from_sleep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt       <= 0;
         from_sleep <= 1'b0;
      end else begin
         wcnt <= (pwr_state == 2'd3) ? wcnt + 1 : 0;
         if (pwr_state == 2'd2)      from_sleep <= 1'b1;
         else if (pwr_state == 2'd1) from_sleep <= 1'b0;
      end
   end

   int lim;
   assign lim = from_sleep ? SLEEP_WAKE_CYC : NAP_WAKE_CYC;

   a_r2_nap_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd0 && req_nap && !req_sleep) |=> (pwr_state == 2'd1 && !adc_shdn_n && !adc_cs_n));

   a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd0 && req_sleep) |=> (pwr_state == 2'd2 && !adc_shdn_n && adc_cs_n));

   a_r4_nap_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd1 && req_sleep) |=> (pwr_state == 2'd2 && $rose(adc_cs_n) && !adc_shdn_n && $stable(adc_shdn_n)));

   a_r5_waking_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd3) |-> (wcnt < lim));

   a_r6_waking_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd3 && wcnt == lim - 1) |=> (pwr_state == 2'd0 && ready));

   a_r7_wake_when_active: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd0 && !req_nap && !req_sleep) |=> (pwr_state == 2'd0));

   a_r8_grant_gated: assert property (@(posedge clk) disable iff (!rst_n)
      conv_grant |-> (ready && conv_req));

   a_r10_ready_only_active: assert property (@(posedge clk) disable iff (!rst_n)
      ready == (pwr_state == 2'd0));
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(
   .NAP_WAKE_CYC  (NAP_WAKE_CYC),
   .SLEEP_WAKE_CYC(SLEEP_WAKE_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_nap   (req_nap),
   .req_sleep (req_sleep),
   .req_wake  (req_wake),
   .conv_req  (conv_req),
   .conv_grant(conv_grant),
   .adc_shdn_n(adc_shdn_n),
   .adc_cs_n  (adc_cs_n),
   .ready     (ready),
   .pwr_state (pwr_state)
);

// File: tb/tb_adc_pwr_seq.sv
module tb_adc_pwr_seq;
   localparam int NAP_D   = 5;
   localparam int SLEEP_D = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_nap = 1'b0, req_sleep = 1'b0, req_wake = 1'b0, conv_req = 1'b0;
   logic conv_grant, adc_shdn_n, adc_cs_n, ready;
   logic [1:0] pwr_state;

   int checks = 0;
   int errors = 0;
   string tag = "R1";
   bit finished = 1'b0;

   always #4 clk = ~clk;

   adc_pwr_seq #(
      .NAP_WAKE_CYC  (NAP_D),
      .SLEEP_WAKE_CYC(SLEEP_D)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_nap   (req_nap),
      .req_sleep (req_sleep),
      .req_wake  (req_wake),
      .conv_req  (conv_req),
      .conv_grant(conv_grant),
      .adc_shdn_n(adc_shdn_n),
      .adc_cs_n  (adc_cs_n),
      .ready     (ready),
      .pwr_state (pwr_state)
   );

   // Behavioural reference: 0 active, 1 nap, 2 sleep, 3 waking (R10).
   int m_st = 0;
   int m_left = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st   <= 0;
         m_left <= 0;
      end else begin
         case (m_st)
            0: if (req_sleep) m_st <= 2; else if (req_nap) m_st <= 1;
            1: if (req_sleep) m_st <= 2;
               else if (req_wake) begin m_st <= 3; m_left <= NAP_D; end
            2: if (req_wake) begin m_st <= 3; m_left <= SLEEP_D; end
            default: begin
               if (m_left - 1 == 0) m_st <= 0;
               m_left <= m_left - 1;
            end
         endcase
      end
   end

   task automatic check(input logic [1:0] act, input logic [1:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         check(pwr_state, 2'(m_st), "pwr_state (R10)");
         check({1'b0, adc_shdn_n}, {1'b0, !(m_st == 1 || m_st == 2)}, "adc_shdn_n");
         check({1'b0, adc_cs_n}, {1'b0, m_st == 2}, "adc_cs_n");
         check({1'b0, ready}, {1'b0, m_st == 0}, "ready");
         check({1'b0, conv_grant}, {1'b0, conv_req && (m_st == 0)}, "conv_grant (R8)");
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic pulse(input logic n, input logic s, input logic w, input string t);
      @(negedge clk); #1;
      tag = t;
      req_nap = n; req_sleep = s; req_wake = w;
      @(negedge clk); #1;
      req_nap = 1'b0; req_sleep = 1'b0; req_wake = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tag = "R1";
      idle(3);
      rst_n = 1'b1;
      idle(2);
      tag = "R8"; conv_req = 1'b1; idle(3); conv_req = 1'b0;
      pulse(0, 0, 1, "R7");            idle(3);
      pulse(1, 0, 0, "R2");            idle(2);
      tag = "R8"; conv_req = 1'b1; idle(2); conv_req = 1'b0;
      pulse(1, 0, 0, "R7");            idle(2);
      pulse(0, 0, 1, "R5");            idle(NAP_D + 3);
      conv_req = 1'b1; idle(2); conv_req = 1'b0;
      pulse(0, 1, 0, "R3");            idle(3);
      pulse(1, 0, 0, "R7");            idle(2);
      pulse(0, 0, 1, "R6");            idle(5);
      pulse(0, 1, 0, "R7");            idle(2);
      pulse(1, 0, 0, "R7");            idle(SLEEP_D);
      pulse(1, 0, 0, "R4");            idle(2);
      pulse(0, 1, 0, "R4");            idle(2);
      pulse(0, 0, 1, "R6");            idle(SLEEP_D + 3);
      pulse(1, 1, 1, "R9");            idle(2);
      pulse(0, 0, 1, "R6");            idle(SLEEP_D + 3);
      pulse(1, 0, 1, "R9");            idle(2);
      pulse(0, 1, 1, "R9");            idle(2);
      pulse(0, 0, 1, "R6");            idle(SLEEP_D + 3);
      pulse(1, 0, 0, "R2");            idle(1);
      pulse(0, 0, 1, "R5");
      tag = "R8"; conv_req = 1'b1; idle(NAP_D + 2); conv_req = 1'b0;
      tag = "R1"; rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule